// File: doc/BRIEF.md
# Decimal Memory-Operand Sequencer

This block runs the bus side of a memory-to-memory decimal operation. It receives two pointer values with their register numbers and an operation code. It lowers the source pointer first and the destination pointer second. It then reads the source byte and the destination byte over a simple request/ready bus and passes both bytes to an external decimal arithmetic unit. When that unit allows it, the block writes the returned byte to the lowered destination address.

When the sequence ends, the block pulses `done` with the cycle cost of the operation. In the same cycle it pulses `ptr_we` with the final pointer values, so that a register file can store them. The negate operation uses only the destination pointer. It reads one byte and writes it back only when the arithmetic unit asserts its write enable.

Top module: `bcd_mem_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `ptr_we` and `bus_req` are all low.
- R2: An add (op 2'b00) or subtract (op 2'b01) makes exactly three bus transfers, in this order: a read at the lowered source address, a read at the lowered destination address, then a write at the lowered destination address.
- R3: A pointer whose register number equals STACK_IDX (default 7) is lowered by 2. A pointer with any other register number is lowered by 1.
- R4: When the source and destination register numbers are equal, the destination is lowered from the value the source step already produced. Both reads and the write use the addresses that result.
- R5: Pointer arithmetic wraps modulo 2^AW.
- R6: While `bus_req` is high and `bus_ready` is low, the outputs `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold their values. A transfer completes in a cycle where both `bus_req` and `bus_ready` are high.
- R7: `done` is a one-cycle pulse. It carries `cost` = 18 for add and subtract, and `cost` = 8 for negate.
- R8: Negate (op 2'b10) lowers only the destination pointer and reads one byte there. It writes back only if `alu_wr_en` is high when the arithmetic unit is asked. The source pointer is returned unchanged.
- R9: `ptr_we` pulses for one cycle together with `done`. In that cycle `src_ptr_upd` and `dst_ptr_upd` hold the final pointer values.
- R10: `start` is ignored while `busy` is high. It is also ignored when op is 2'b11: no transfer and no `done` follow.
- R11: During `alu_go`, `alu_src` holds the source byte that was read (0 for negate) and `alu_dst` holds the destination byte. The byte written is the `alu_res` value sampled during `alu_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 00 add, 01 subtract, 10 negate, 11 reserved |
| src_idx | input | IW (3) | Source register number |
| dst_idx | input | IW (3) | Destination register number |
| src_ptr | input | AW (32) | Source pointer before the operation |
| dst_ptr | input | AW (32) | Destination pointer before the operation |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| cost | output | CW (5) | Cycle cost, valid while `done` is high |
| ptr_we | output | 1 | Pointer update strobe |
| src_ptr_upd | output | AW (32) | Updated source pointer |
| dst_ptr_upd | output | AW (32) | Updated destination pointer |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | AW (32) | Byte address |
| bus_wdata | output | DW (8) | Write data |
| bus_ready | input | 1 | Transfer accepted / read data valid |
| bus_rdata | input | DW (8) | Read data |
| alu_op | output | 2 | Operation latched for the arithmetic unit |
| alu_go | output | 1 | Operands valid, result sampled this cycle |
| alu_src | output | DW (8) | Source operand byte |
| alu_dst | output | DW (8) | Destination operand byte |
| alu_res | input | DW (8) | Result byte from the arithmetic unit |
| alu_wr_en | input | 1 | Result is to be written back |

## Verification
The bench uses the default parameters: 32-bit pointers, byte data, and stack register number 7. The full 32-bit width lets pointers at 0 and 1 wrap to the top of the address space, and register 7 brings the double step within reach on either operand and on a shared register. A bench memory model has a settable latency. Running it with zero waits and with three waits exercises both back-to-back transfers and held requests.

// File: rtl/bcd_mem_seq_pkg.sv
package bcd_mem_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEC_SRC,
        S_DEC_DST,
        S_RD_SRC,
        S_RD_DST,
        S_CALC,
        S_WR,
        S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_NEG = 2'b10,
        OP_RSV = 2'b11
    } seq_op_e;

endpackage

// File: rtl/bcd_mem_seq_step.sv
module bcd_mem_seq_step #(
    parameter int AW        = 32,
    parameter int IW        = 3,
    parameter int STACK_IDX = 7
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] lowered
);
    localparam logic [AW-1:0] STEP_WIDE   = AW'(2);
    localparam logic [AW-1:0] STEP_NARROW = AW'(1);
    localparam logic [IW-1:0] STACK_NUM   = IW'(STACK_IDX);

    always_comb begin
        lowered = base - ((idx == STACK_NUM) ? STEP_WIDE : STEP_NARROW);
    end
endmodule

// File: rtl/bcd_mem_seq_ctrl.sv
module bcd_mem_seq_ctrl
    import bcd_mem_seq_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 8,
    parameter int IW          = 3,
    parameter int COST_ARITH  = 18,
    parameter int COST_NEG    = 8,
    parameter int CW          = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op,
    input  logic [IW-1:0]      src_idx,
    input  logic [IW-1:0]      dst_idx,
    input  logic [AW-1:0]      src_ptr,
    input  logic [AW-1:0]      dst_ptr,
    output logic [1:0][AW-1:0] step_base,
    output logic [1:0][IW-1:0] step_idx,
    input  logic [1:0][AW-1:0] step_out,
    output logic               busy,
    output logic               done,
    output logic [CW-1:0]      cost,
    output logic               ptr_we,
    output logic [AW-1:0]      src_ptr_upd,
    output logic [AW-1:0]      dst_ptr_upd,
    output logic               bus_req,
    output logic               bus_we,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_wdata,
    input  logic               bus_ready,
    input  logic [DW-1:0]      bus_rdata,
    output logic [1:0]         alu_op,
    output logic               alu_go,
    output logic [DW-1:0]      alu_src,
    output logic [DW-1:0]      alu_dst,
    input  logic [DW-1:0]      alu_res,
    input  logic               alu_wr_en
);
    typedef struct packed {
        seq_state_e    state;
        seq_op_e       op;
        logic [AW-1:0] sp;
        logic [AW-1:0] dp;
        logic [IW-1:0] si;
        logic [IW-1:0] di;
        logic [DW-1:0] sb;
        logic [DW-1:0] db;
        logic [DW-1:0] rb;
    } seq_regs_t;

    localparam logic [CW-1:0] C_ARITH = CW'(COST_ARITH);
    localparam logic [CW-1:0] C_NEG   = CW'(COST_NEG);

    seq_regs_t r_q, r_d;
    logic      shared_reg;

    always_comb begin
        shared_reg   = (r_q.si == r_q.di) && (r_q.op != OP_NEG);
        step_base[0] = r_q.sp;
        step_idx[0]  = r_q.si;
        step_base[1] = shared_reg ? r_q.sp : r_q.dp;
        step_idx[1]  = r_q.di;
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            S_IDLE: begin
                if (start && (seq_op_e'(op) != OP_RSV)) begin
                    r_d.op    = seq_op_e'(op);
                    r_d.sp    = src_ptr;
                    r_d.dp    = dst_ptr;
                    r_d.si    = src_idx;
                    r_d.di    = dst_idx;
                    r_d.sb    = '0;
                    r_d.state = (seq_op_e'(op) == OP_NEG) ? S_DEC_DST : S_DEC_SRC;
                end
            end
            S_DEC_SRC: begin
                r_d.sp    = step_out[0];
                r_d.state = S_DEC_DST;
            end
            S_DEC_DST: begin
                r_d.dp    = step_out[1];
                r_d.state = (r_q.op == OP_NEG) ? S_RD_DST : S_RD_SRC;
            end
            S_RD_SRC: begin
                if (bus_ready) begin
                    r_d.sb    = bus_rdata;
                    r_d.state = S_RD_DST;
                end
            end
            S_RD_DST: begin
                if (bus_ready) begin
                    r_d.db    = bus_rdata;
                    r_d.state = S_CALC;
                end
            end
            S_CALC: begin
                r_d.rb    = alu_res;
                r_d.state = alu_wr_en ? S_WR : S_FIN;
            end
            S_WR: begin
                if (bus_ready) begin
                    r_d.state = S_FIN;
                end
            end
            S_FIN: begin
                r_d.state = S_IDLE;
            end
            default: begin
                r_d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= S_IDLE;
            r_q.op    <= OP_ADD;
            r_q.sp    <= '0;
            r_q.dp    <= '0;
            r_q.si    <= '0;
            r_q.di    <= '0;
            r_q.sb    <= '0;
            r_q.db    <= '0;
            r_q.rb    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy        = (r_q.state != S_IDLE);
        done        = (r_q.state == S_FIN);
        ptr_we      = (r_q.state == S_FIN);
        cost        = '0;
        if (r_q.state == S_FIN) begin
            cost = (r_q.op == OP_NEG) ? C_NEG : C_ARITH;
        end
        src_ptr_upd = r_q.sp;
        dst_ptr_upd = r_q.dp;
        bus_req     = (r_q.state == S_RD_SRC) || (r_q.state == S_RD_DST) ||
                      (r_q.state == S_WR);
        bus_we      = (r_q.state == S_WR);
        bus_addr    = (r_q.state == S_RD_SRC) ? r_q.sp : r_q.dp;
        bus_wdata   = r_q.rb;
        alu_op      = r_q.op;
        alu_go      = (r_q.state == S_CALC);
        alu_src     = r_q.sb;
        alu_dst     = r_q.db;
    end
endmodule

// File: rtl/bcd_mem_seq.sv
module bcd_mem_seq #(
    parameter int AW         = 32,
    parameter int DW         = 8,
    parameter int IW         = 3,
    parameter int STACK_IDX  = 7,
    parameter int COST_ARITH = 18,
    parameter int COST_NEG   = 8,
    localparam int CW        = $clog2(COST_ARITH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [IW-1:0] src_idx,
    input  logic [IW-1:0] dst_idx,
    input  logic [AW-1:0] src_ptr,
    input  logic [AW-1:0] dst_ptr,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cost,
    output logic          ptr_we,
    output logic [AW-1:0] src_ptr_upd,
    output logic [AW-1:0] dst_ptr_upd,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic [1:0]    alu_op,
    output logic          alu_go,
    output logic [DW-1:0] alu_src,
    output logic [DW-1:0] alu_dst,
    input  logic [DW-1:0] alu_res,
    input  logic          alu_wr_en
);
    localparam int NSTEP = 2;

    logic [NSTEP-1:0][AW-1:0] step_base;
    logic [NSTEP-1:0][IW-1:0] step_idx;
    logic [NSTEP-1:0][AW-1:0] step_out;

    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        bcd_mem_seq_step #(
            .AW        (AW),
            .IW        (IW),
            .STACK_IDX (STACK_IDX)
        ) u_step (
            .base    (step_base[g]),
            .idx     (step_idx[g]),
            .lowered (step_out[g])
        );
    end

    bcd_mem_seq_ctrl #(
        .AW         (AW),
        .DW         (DW),
        .IW         (IW),
        .COST_ARITH (COST_ARITH),
        .COST_NEG   (COST_NEG),
        .CW         (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op          (op),
        .src_idx     (src_idx),
        .dst_idx     (dst_idx),
        .src_ptr     (src_ptr),
        .dst_ptr     (dst_ptr),
        .step_base   (step_base),
        .step_idx    (step_idx),
        .step_out    (step_out),
        .busy        (busy),
        .done        (done),
        .cost        (cost),
        .ptr_we      (ptr_we),
        .src_ptr_upd (src_ptr_upd),
        .dst_ptr_upd (dst_ptr_upd),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .alu_op      (alu_op),
        .alu_go      (alu_go),
        .alu_src     (alu_src),
        .alu_dst     (alu_dst),
        .alu_res     (alu_res),
        .alu_wr_en   (alu_wr_en)
    );
endmodule

// File: rtl/bcd_mem_seq_chk.sv
module bcd_mem_seq_chk #(
    parameter int AW         = 32,
    parameter int DW         = 8,
    parameter int COST_ARITH = 18,
    parameter int COST_NEG   = 8,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] cost,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ready,
    input logic [1:0]    alu_op,
    input logic          alu_go,
    input logic [DW-1:0] alu_res
);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) &&
                                     $stable(bus_we) && $stable(bus_wdata)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cost_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cost == ((alu_op == 2'b10) ? CW'(COST_NEG) : CW'(COST_ARITH))));

    p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_write_after_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req && bus_we) |-> $past(alu_go));

    p_write_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && $past(alu_go)) |-> (bus_wdata == $past(alu_res)));
endmodule

bind bcd_mem_seq bcd_mem_seq_chk #(
    .AW         (AW),
    .DW         (DW),
    .COST_ARITH (COST_ARITH),
    .COST_NEG   (COST_NEG),
    .CW         (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .cost      (cost),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .alu_op    (alu_op),
    .alu_go    (alu_go),
    .alu_res   (alu_res)
);

// File: tb/bcd_mem_seq_tb.sv
`timescale 1ns/1ps
module bcd_mem_seq_tb;
    localparam int AW = 32;
    localparam int DW = 8;
    localparam int IW = 3;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [IW-1:0] src_idx = '0;
    logic [IW-1:0] dst_idx = '0;
    logic [AW-1:0] src_ptr = '0;
    logic [AW-1:0] dst_ptr = '0;
    logic          busy, done, ptr_we, bus_req, bus_we, alu_go;
    logic [CW-1:0] cost;
    logic [AW-1:0] src_ptr_upd, dst_ptr_upd, bus_addr;
    logic [DW-1:0] bus_wdata, alu_src, alu_dst, alu_res;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready = 1'b0;
    logic [1:0]    alu_op;
    logic          alu_we_tb = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 0;
    int wcnt     = 0;
    bit finished = 0;

    logic [DW-1:0] mem [256];
    logic [AW-1:0] log_addr [8];
    logic          log_we   [8];
    logic [DW-1:0] log_dat  [8];
    int            log_n = 0;
    int            stab_err = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_addr = '0;

    logic [CW-1:0] got_cost;
    logic [AW-1:0] got_sp, got_dp;
    logic          got_pwe;
    bit            got_done;

    always #2 clk = ~clk;

    bcd_mem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_idx(src_idx), .dst_idx(dst_idx), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .busy(busy), .done(done), .cost(cost), .ptr_we(ptr_we),
        .src_ptr_upd(src_ptr_upd), .dst_ptr_upd(dst_ptr_upd),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .alu_op(alu_op), .alu_go(alu_go), .alu_src(alu_src), .alu_dst(alu_dst),
        .alu_res(alu_res), .alu_wr_en(alu_we_tb)
    );

    // Simple arithmetic stand-in: binary sums are enough to prove operand routing.
    assign alu_res = (alu_op == 2'b00) ? (alu_src + alu_dst) :
                     (alu_op == 2'b01) ? (alu_dst - alu_src) : (8'h00 - alu_dst);
    assign bus_rdata = mem[bus_addr[7:0]];

    // Ready generator with programmable latency, driven away from the active edge.
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_ready <= 1'b0;
            wcnt      <= 0;
        end else if (bus_ready) begin
            wcnt      <= 0;
            bus_ready <= (lat == 0);
        end else if (wcnt >= lat) begin
            bus_ready <= 1'b1;
        end else begin
            wcnt <= wcnt + 1;
        end
    end

    always @(posedge clk) begin
        if (bus_req && pend && (bus_addr != pend_addr)) stab_err <= stab_err + 1;
        pend      <= bus_req && !bus_ready;
        pend_addr <= bus_addr;
        if (bus_req && bus_ready) begin
            if (log_n < 8) begin
                log_addr[log_n] <= bus_addr;
                log_we[log_n]   <= bus_we;
                log_dat[log_n]  <= bus_wdata;
            end
            log_n <= log_n + 1;
            if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [IW-1:0] si,
                          input logic [IW-1:0] di, input logic [AW-1:0] sp,
                          input logic [AW-1:0] dp);
        @(negedge clk);
        log_n   = 0;
        op      = o;
        src_idx = si;
        dst_idx = di;
        src_ptr = sp;
        dst_ptr = dp;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        got_done = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                got_done = 1;
                got_cost = cost;
                got_sp   = src_ptr_upd;
                got_dp   = dst_ptr_upd;
                got_pwe  = ptr_we;
                break;
            end
            @(negedge clk);
        end
        chk(got_done, "R7 done seen", AW'(got_done), 1);
        @(negedge clk);
        chk(!done && !ptr_we, "R7 R9 single-cycle pulse", AW'({done, ptr_we}), 0);
    endtask

    task automatic chk_access(input int k, input logic [AW-1:0] a, input logic w,
                              input string req);
        chk(log_addr[k] == a, req, log_addr[k], a);
        chk(log_we[k] == w, req, AW'(log_we[k]), AW'(w));
    endtask

    task automatic t_reset;
        chk(!busy && !done && !ptr_we && !bus_req, "R1 idle after reset",
            AW'({busy, done, ptr_we, bus_req}), 0);
    endtask

    task automatic t_add_basic;
        mem[8'h1F] = 8'h25;
        mem[8'h2F] = 8'h13;
        alu_we_tb  = 1'b1;
        run_op(2'b00, 3'd2, 3'd5, 32'h20, 32'h30);
        chk(log_n == 3, "R2 three transfers", AW'(log_n), 3);
        chk_access(0, 32'h1F, 1'b0, "R2 first read at source");
        chk_access(1, 32'h2F, 1'b0, "R2 second read at destination");
        chk_access(2, 32'h2F, 1'b1, "R2 write at destination");
        chk(log_dat[2] == 8'h38, "R11 written byte", AW'(log_dat[2]), 32'h38);
        chk(got_cost == 5'd18, "R7 add cost", AW'(got_cost), 18);
        chk(got_pwe == 1'b1, "R9 strobe with done", AW'(got_pwe), 1);
        chk(got_sp == 32'h1F, "R9 source update", got_sp, 32'h1F);
        chk(got_dp == 32'h2F, "R9 destination update", got_dp, 32'h2F);
    endtask

    task automatic t_stack_step;
        mem[8'h4E] = 8'h05;
        mem[8'h5F] = 8'h09;
        run_op(2'b01, 3'd7, 3'd1, 32'h50, 32'h60);
        chk_access(0, 32'h4E, 1'b0, "R3 source reg 7 steps by 2");
        chk_access(1, 32'h5F, 1'b0, "R3 other reg steps by 1");
        chk(log_dat[2] == 8'h04, "R11 subtract operands", AW'(log_dat[2]), 32'h04);
        chk(got_cost == 5'd18, "R7 sub cost", AW'(got_cost), 18);
        run_op(2'b01, 3'd0, 3'd7, 32'h80, 32'h90);
        chk(got_sp == 32'h7F && got_dp == 32'h8E, "R3 destination reg 7 steps by 2",
            got_dp, 32'h8E);
    endtask

    task automatic t_same_reg;
        run_op(2'b00, 3'd3, 3'd3, 32'h40, 32'h40);
        chk_access(0, 32'h3F, 1'b0, "R4 shared reg source read");
        chk_access(1, 32'h3E, 1'b0, "R4 shared reg destination read");
        chk_access(2, 32'h3E, 1'b1, "R4 shared reg write");
        chk(got_dp == 32'h3E, "R4 shared reg final pointer", got_dp, 32'h3E);
        run_op(2'b00, 3'd7, 3'd7, 32'h40, 32'h40);
        chk(got_sp == 32'h3E && got_dp == 32'h3C, "R4 R3 shared stack reg",
            got_dp, 32'h3C);
    endtask

    task automatic t_wrap;
        mem[8'hFF] = 8'h11;
        run_op(2'b00, 3'd1, 3'd7, 32'h0, 32'h1);
        chk(got_sp == 32'hFFFF_FFFF, "R5 source wraps", got_sp, 32'hFFFF_FFFF);
        chk(got_dp == 32'hFFFF_FFFF, "R5 destination wraps", got_dp, 32'hFFFF_FFFF);
        chk(mem[8'hFF] == 8'h22, "R5 write at wrapped address", AW'(mem[8'hFF]), 32'h22);
    endtask

    task automatic t_neg;
        mem[8'h6F] = 8'h01;
        alu_we_tb  = 1'b1;
        run_op(2'b10, 3'd2, 3'd4, 32'h1234, 32'h70);
        chk(log_n == 2, "R8 negate transfers", AW'(log_n), 2);
        chk_access(0, 32'h6F, 1'b0, "R8 negate read");
        chk_access(1, 32'h6F, 1'b1, "R8 negate write");
        chk(mem[8'h6F] == 8'hFF, "R11 negate source operand zero", AW'(mem[8'h6F]), 32'hFF);
        chk(got_cost == 5'd8, "R7 negate cost", AW'(got_cost), 8);
        chk(got_sp == 32'h1234, "R8 source unchanged", got_sp, 32'h1234);
        chk(got_dp == 32'h6F, "R8 destination lowered", got_dp, 32'h6F);
        mem[8'h5F] = 8'h42;
        alu_we_tb  = 1'b0;
        run_op(2'b10, 3'd0, 3'd6, 32'h0, 32'h60);
        alu_we_tb  = 1'b1;
        chk(log_n == 1, "R8 write skipped", AW'(log_n), 1);
        chk(mem[8'h5F] == 8'h42, "R8 memory untouched", AW'(mem[8'h5F]), 32'h42);
        chk(got_cost == 5'd8, "R7 negate cost without write", AW'(got_cost), 8);
    endtask

    task automatic t_wait_states;
        mem[8'h1F] = 8'h03;
        mem[8'h2F] = 8'h04;
        lat        = 3;
        stab_err   = 0;
        run_op(2'b00, 3'd2, 3'd5, 32'h20, 32'h30);
        chk(log_n == 3, "R6 one transfer per handshake", AW'(log_n), 3);
        chk(stab_err == 0, "R6 request held while waiting", AW'(stab_err), 0);
        chk(mem[8'h2F] == 8'h07, "R6 data after waits", AW'(mem[8'h2F]), 32'h07);
        lat = 0;
    endtask

    task automatic t_ignored_start;
        @(negedge clk);
        log_n   = 0;
        op      = 2'b11;
        src_ptr = 32'h20;
        dst_ptr = 32'h30;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (busy || done || bus_req) n_fail += 0;
        end
        chk(!busy && log_n == 0, "R10 reserved op ignored", AW'(log_n), 0);
        // Second start during a running operation.
        lat = 3;
        @(negedge clk);
        log_n   = 0;
        op      = 2'b00;
        src_idx = 3'd2;
        dst_idx = 3'd5;
        src_ptr = 32'h20;
        dst_ptr = 32'h30;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        repeat (4) @(negedge clk);
        op      = 2'b10;
        dst_ptr = 32'h90;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(dst_ptr_upd == 32'h2F, "R10 start while busy ignored", dst_ptr_upd, 32'h2F);
        repeat (5) @(negedge clk);
        chk(!busy && log_n == 3, "R10 no second sequence", AW'(log_n), 3);
        lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_basic();
        t_stack_step();
        t_same_reg();
        t_wrap();
        t_neg();
        t_wait_states();
        t_ignored_start();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule